// File: doc/BRIEF.md
# HDLC transmit line fill controller

This block sits at the serial output of an HDLC-style transmitter. It accepts frame octets over a valid/ready handshake and shifts them out MSB first. Between frames it fills the line with either all-ones idle octets or flag octets. Which fill is used depends on the fill-select input, the bus-mode input and the clock mode together. Flag framing, zero-bit insertion, CRC and the timeslot assigner are handled elsewhere.

Bit shifting is qualified by one of four clock-gating modes applied to an external bit-clock enable. An optional half-rate setting shifts one bit per two qualified enables. The pin can be driven push-pull, or open-drain through an output-enable that pulls the line low only for 0 bits. In bus mode with push-pull drive, the pin is held at 1 whenever no frame data is on the line or the assigned timeslot is closed.

All configuration inputs are sampled together at octet boundaries only. A new frame therefore always starts on a fill-octet boundary, and a fill pattern is never cut short.

Top module: `hdlc_fill_tx`

## Requirements
- R1: After reset `txData` is 1, `txOe` is 0 (line released) and `frameReady` is 0. The reset octet in the shifter is all ones, with clock mode 0, single rate, open-drain drive and no bus mode in effect.
- R2: With `fillFlag` = 0, `busMode` = 0 and no frame octet accepted, each octet sent is 8'b11111111.
- R3: With `fillFlag` = 1, `busMode` = 0 and a clock mode other than 3, each fill octet is 8'b01111110. Fill and frame octets go out MSB (bit 7) first.
- R4: With `busMode` = 1 the fill octet is all ones, whatever the value of `fillFlag`.
- R5: With `clkMode` = 2'b11 the fill octet is all ones, whatever the value of `fillFlag`.
- R6: `frameReady` is high only in the cycle that shifts out bit 0 of the current octet. An octet accepted there (`frameValid` and `frameReady` both high) is the next octet sent. Fill resumes after it when nothing further is accepted.
- R7: With `clkMode` = 2'b00, every cycle with `bitClkEn` high shifts one bit. With `bitClkEn` low, nothing shifts.
- R8: With `clkMode` = 2'b01, a bit shifts only when `bitClkEn` and `enStrobe` are both high.
- R9: With `clkMode` = 2'b10, a bit shifts only when `bitClkEn` and `slotActive` are both high.
- R10: With `clkMode` = 2'b11, a bit shifts once for every 4 (`INT_DIV`) cycles with `bitClkEn` high. The internal strobe ignores `enStrobe` and `slotActive`.
- R11: With `dblRate` = 1, one bit shifts per two qualified enables. The phase restarts at each octet boundary.
- R12: With `pushPull` = 1, `txOe` is 1. With `busMode` = 1 as well, `txData` is 1 while fill is on the line, and also while clock mode 2 has `slotActive` low.
- R13: With `pushPull` = 0, `txOe` equals the inverse of `txData`, so the pin is pulled low only for 0 bits.
- R14: Changes to `fillFlag`, `busMode`, `pushPull`, `dblRate` and `clkMode` take effect only from the next octet boundary. The octet in progress keeps its pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fillFlag | input | 1 | Fill select: 0 all-ones, 1 flag octets |
| busMode | input | 1 | Shared-bus operation, forces ones fill |
| pushPull | input | 1 | 1 push-pull drive, 0 open-drain emulation |
| dblRate | input | 1 | One bit per two qualified enables |
| clkMode | input | 2 | Gating mode 00 free, 01 strobe, 10 slot, 11 internal |
| bitClkEn | input | 1 | External bit-clock enable |
| enStrobe | input | 1 | External enable strobe (mode 01) |
| slotActive | input | 1 | Assigned timeslot active (mode 10) |
| frameData | input | 8 | Frame octet to send |
| frameValid | input | 1 | Frame octet available |
| frameReady | output | 1 | Frame octet taken this cycle |
| txData | output | 1 | Serial data level |
| txOe | output | 1 | Output enable (open drain: pull low) |

## Verification
A wrong bit counter or rate phase shows at once as `frameReady` pulsing at the wrong pulse within an octet. It also shows one octet later as a shifted or interleaved serial pattern. A wrongly chosen fill pattern or a configuration latched mid-octet appears within one octet as a bad bit on `txData`. Wrong gating in modes 1 to 3 shows in the first gated pulse, because a bit moves when the line should have held still. A drive-form error appears on `txOe` in the same cycle as the bit it governs.

// File: rtl/hdlc_fill_pkg.sv
package hdlc_fill_pkg;

  typedef enum logic [1:0] {
    CK_FREE   = 2'b00,
    CK_STROBE = 2'b01,
    CK_SLOT   = 2'b10,
    CK_INT    = 2'b11
  } clkMode_e;

  typedef struct packed {
    logic     flagFill;
    logic     busMode;
    logic     pushPull;
    logic     dblRate;
    clkMode_e clkMode;
  } lineCfg_t;

  // strobes and levels from control to datapath
  typedef struct packed {
    logic shift;
    logic load;
    logic takeData;
    logic flagFill;
    logic busMode;
    logic pushPull;
    logic slotClosed;
  } dpCmd_t;

endpackage

// File: rtl/hdlc_fill_ctrl.sv
module hdlc_fill_ctrl
  import hdlc_fill_pkg::*;
#(
  parameter int OCT_W   = 8,
  parameter int INT_DIV = 4,
  localparam int CNT_W  = $clog2(OCT_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  lineCfg_t         cfgIn,
  input  logic             bitClkEn,
  input  logic             enStrobe,
  input  logic             slotActive,
  input  logic             frameValid,
  output logic             frameReady,
  output dpCmd_t           cmd,
  output lineCfg_t         cfgQ,
  output logic [CNT_W-1:0] bitCnt
);

  localparam int DIV_W = (INT_DIV > 1) ? $clog2(INT_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(OCT_W - 1);

  logic intTick;
  logic gateOpen;
  logic qualEn;
  logic ratePhase;
  logic shiftEv;
  logic loadEv;
  logic nextFlag;

  // internal enable strobe: one tick per INT_DIV bit-clock enables
  generate
    if (INT_DIV > 1) begin : g_div
      localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(INT_DIV - 1);
      logic [DIV_W-1:0] intCnt;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          intCnt <= '0;
        end else if (bitClkEn) begin
          intCnt <= (intCnt == DIV_LAST) ? '0 : intCnt + 1'b1;
        end
      end
      assign intTick = bitClkEn && (intCnt == DIV_LAST);
    end else begin : g_nodiv
      assign intTick = bitClkEn;
    end
  endgenerate

  always_comb begin
    unique case (cfgQ.clkMode)
      CK_FREE:   gateOpen = 1'b1;
      CK_STROBE: gateOpen = enStrobe;
      CK_SLOT:   gateOpen = slotActive;
      default:   gateOpen = 1'b1;
    endcase
  end

  assign qualEn   = (cfgQ.clkMode == CK_INT) ? intTick : (bitClkEn & gateOpen);
  assign shiftEv  = qualEn & (~cfgQ.dblRate | ratePhase);
  assign loadEv   = shiftEv & (bitCnt == LAST_BIT);
  assign frameReady = loadEv;

  // fill choice for the octet loaded at this boundary uses the config latched now
  assign nextFlag = cfgIn.flagFill & ~cfgIn.busMode & (cfgIn.clkMode != CK_INT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ      <= '0;
      bitCnt    <= '0;
      ratePhase <= 1'b0;
    end else begin
      if (loadEv) begin
        cfgQ      <= cfgIn;
        bitCnt    <= '0;
        ratePhase <= 1'b0;
      end else begin
        if (shiftEv) bitCnt <= bitCnt + 1'b1;
        if (qualEn && cfgQ.dblRate) ratePhase <= ~ratePhase;
      end
    end
  end

  always_comb begin
    cmd.shift      = shiftEv;
    cmd.load       = loadEv;
    cmd.takeData   = loadEv & frameValid;
    cmd.flagFill   = nextFlag;
    cmd.busMode    = cfgQ.busMode;
    cmd.pushPull   = cfgQ.pushPull;
    cmd.slotClosed = (cfgQ.clkMode == CK_SLOT) & ~slotActive;
  end

endmodule

// File: rtl/hdlc_fill_dp.sv
module hdlc_fill_dp
  import hdlc_fill_pkg::*;
#(
  parameter int OCT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           cmd,
  input  logic [OCT_W-1:0] frameData,
  output logic             txData,
  output logic             txOe,
  output logic             dataPhase
);

  localparam logic [OCT_W-1:0] FLAG_PAT = {1'b0, {(OCT_W-2){1'b1}}, 1'b0};
  localparam logic [OCT_W-1:0] IDLE_PAT = '1;

  logic [OCT_W-1:0] shReg;
  logic             forceOne;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg     <= IDLE_PAT;
      dataPhase <= 1'b0;
    end else if (cmd.load) begin
      shReg     <= cmd.takeData ? frameData : (cmd.flagFill ? FLAG_PAT : IDLE_PAT);
      dataPhase <= cmd.takeData;
    end else if (cmd.shift) begin
      shReg     <= {shReg[OCT_W-2:0], 1'b1};
    end
  end

  // on a shared bus the line rests at 1 outside data and outside the slot
  assign forceOne = cmd.busMode & (~dataPhase | cmd.slotClosed);
  assign txData   = forceOne | shReg[OCT_W-1];
  assign txOe     = cmd.pushPull | ~txData;

endmodule

// File: rtl/hdlc_fill_tx.sv
module hdlc_fill_tx
  import hdlc_fill_pkg::*;
#(
  parameter int OCT_W   = 8,
  parameter int INT_DIV = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fillFlag,
  input  logic             busMode,
  input  logic             pushPull,
  input  logic             dblRate,
  input  logic [1:0]       clkMode,
  input  logic             bitClkEn,
  input  logic             enStrobe,
  input  logic             slotActive,
  input  logic [OCT_W-1:0] frameData,
  input  logic             frameValid,
  output logic             frameReady,
  output logic             txData,
  output logic             txOe
);

  localparam int CNT_W = $clog2(OCT_W);

  lineCfg_t         cfgIn;
  lineCfg_t         cfgQ;
  dpCmd_t           cmd;
  logic [CNT_W-1:0] bitCnt;
  logic             dataPhase;

  always_comb begin
    cfgIn.flagFill = fillFlag;
    cfgIn.busMode  = busMode;
    cfgIn.pushPull = pushPull;
    cfgIn.dblRate  = dblRate;
    cfgIn.clkMode  = clkMode_e'(clkMode);
  end

  hdlc_fill_ctrl #(.OCT_W(OCT_W), .INT_DIV(INT_DIV)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgIn(cfgIn), .bitClkEn(bitClkEn),
    .enStrobe(enStrobe), .slotActive(slotActive), .frameValid(frameValid),
    .frameReady(frameReady), .cmd(cmd), .cfgQ(cfgQ), .bitCnt(bitCnt)
  );

  hdlc_fill_dp #(.OCT_W(OCT_W)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .frameData(frameData),
    .txData(txData), .txOe(txOe), .dataPhase(dataPhase)
  );

endmodule

// File: rtl/hdlc_fill_tx_chk.sv
module hdlc_fill_tx_chk
  import hdlc_fill_pkg::*;
#(
  parameter int OCT_W = 8,
  localparam int CNT_W = $clog2(OCT_W)
) (
  input logic             clk,
  input logic             rstN,
  input logic             bitClkEn,
  input logic             frameReady,
  input logic             txData,
  input logic             txOe,
  input lineCfg_t         cfgQ,
  input logic [CNT_W-1:0] bitCnt,
  input logic             dataPhase
);

  // R6
  ready_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameReady |-> (bitCnt == CNT_W'(OCT_W - 1)));

  // R7
  ready_clk_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameReady |-> bitClkEn);

  // R7
  hold_no_clk_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!bitClkEn && !cfgQ.busMode) |=> $stable(txData));

  // R4
  fill_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((cfgQ.busMode || cfgQ.clkMode == CK_INT) && !dataPhase) |-> txData);

  // R12
  pp_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgQ.pushPull |-> txOe);

endmodule

bind hdlc_fill_tx hdlc_fill_tx_chk #(.OCT_W(OCT_W)) chk_i (
  .clk(clk), .rstN(rstN), .bitClkEn(bitClkEn), .frameReady(frameReady),
  .txData(txData), .txOe(txOe), .cfgQ(cfgQ), .bitCnt(bitCnt),
  .dataPhase(dataPhase)
);

// File: tb/hdlc_fill_tx_tb_top.sv
module hdlc_fill_tx_tb_top;

  localparam logic [7:0] FLAG = 8'b01111110;
  localparam logic [7:0] ONES = 8'hFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fillFlag = 1'b0, busMode = 1'b0, pushPull = 1'b0, dblRate = 1'b0;
  logic [1:0] clkMode = 2'b00;
  logic bitClkEn = 1'b0, enStrobe = 1'b1, slotActive = 1'b1;
  logic [7:0] frameData = 8'h00;
  logic frameValid = 1'b0;
  logic frameReady, txData, txOe;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hdlc_fill_tx #(.OCT_W(8), .INT_DIV(4)) dut_i (
    .clk(clk), .rstN(rstN), .fillFlag(fillFlag), .busMode(busMode),
    .pushPull(pushPull), .dblRate(dblRate), .clkMode(clkMode),
    .bitClkEn(bitClkEn), .enStrobe(enStrobe), .slotActive(slotActive),
    .frameData(frameData), .frameValid(frameValid), .frameReady(frameReady),
    .txData(txData), .txOe(txOe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // called at a negedge; one bit-clock enable cycle, sampling before the edge
  task automatic pulse(input logic stb, input logic slot,
                       output logic b, output logic oe, output logic rdy);
    enStrobe = stb;
    slotActive = slot;
    bitClkEn = 1'b1;
    #1;
    b = txData;
    oe = txOe;
    rdy = frameReady;
    @(negedge clk);
    bitClkEn = 1'b0;
    if (rdy && frameValid) frameValid = 1'b0;
  endtask

  task automatic syncBoundary();
    logic b, oe, rdy;
    bit seen = 1'b0;
    for (int i = 0; i < 100 && !seen; i++) begin
      pulse(1'b1, 1'b1, b, oe, rdy);
      if (rdy) seen = 1'b1;
    end
    if (!seen) chk("R6 boundary reached", 0, 1);
  endtask

  task automatic readOctet(output logic [7:0] v, output int rdyIdx, output logic odOk,
                           output logic ppOk);
    logic b, oe, rdy;
    v = '0; rdyIdx = -1; odOk = 1'b1; ppOk = 1'b1;
    for (int i = 0; i < 8; i++) begin
      pulse(1'b1, 1'b1, b, oe, rdy);
      v = {v[6:0], b};
      if (rdy) rdyIdx = i;
      if (oe !== ~b) odOk = 1'b0;
      if (oe !== 1'b1) ppOk = 1'b0;
    end
  endtask

  task automatic t_reset();
    chk("R1 txData after reset", txData, 1);
    chk("R1 txOe after reset", txOe, 0);
    chk("R1 frameReady after reset", frameReady, 0);
  endtask

  task automatic t_idle();
    logic [7:0] v; int r; logic od, pp;
    readOctet(v, r, od, pp);
    chk("R2 reset octet ones", v, ONES);
    chk("R7 ready on 8th enable in mode 0", r, 7);
    readOctet(v, r, od, pp);
    chk("R2 idle fill ones", v, ONES);
    chk("R13 open drain oe released on ones", od, 1);
  endtask

  task automatic t_flag();
    logic [7:0] v; int r; logic od, pp;
    fillFlag = 1'b1;
    syncBoundary();
    readOctet(v, r, od, pp);
    chk("R3 flag fill", v, FLAG);
    chk("R13 open drain oe is inverse of data", od, 1);
  endtask

  task automatic t_midcfg();
    logic [7:0] v; int r; logic od, pp;
    logic b, oe, rdy;
    v = '0;
    for (int i = 0; i < 3; i++) begin
      pulse(1'b1, 1'b1, b, oe, rdy);
      v = {v[6:0], b};
    end
    fillFlag = 1'b0;
    for (int i = 3; i < 8; i++) begin
      pulse(1'b1, 1'b1, b, oe, rdy);
      v = {v[6:0], b};
    end
    chk("R14 octet in progress keeps flag", v, FLAG);
    readOctet(v, r, od, pp);
    chk("R14 new fill from next boundary", v, ONES);
  endtask

  task automatic t_frame();
    logic [7:0] v; int r; logic od, pp;
    logic b, oe, rdy;
    int early = 0;
    fillFlag = 1'b1;
    syncBoundary();
    for (int i = 0; i < 3; i++) pulse(1'b1, 1'b1, b, oe, rdy);
    frameData = 8'hA5;
    frameValid = 1'b1;
    for (int i = 3; i < 7; i++) begin
      pulse(1'b1, 1'b1, b, oe, rdy);
      if (rdy) early++;
    end
    chk("R6 no ready mid octet", early, 0);
    pulse(1'b1, 1'b1, b, oe, rdy);
    chk("R6 ready at octet end", rdy, 1);
    readOctet(v, r, od, pp);
    chk("R3 frame octet MSB first", v, 8'hA5);
    readOctet(v, r, od, pp);
    chk("R6 fill resumes after frame", v, FLAG);
  endtask

  task automatic t_bus();
    logic [7:0] v; int r; logic od, pp;
    busMode = 1'b1;
    fillFlag = 1'b1;
    syncBoundary();
    readOctet(v, r, od, pp);
    chk("R4 bus mode forces ones", v, ONES);
    busMode = 1'b0;
    syncBoundary();
  endtask

  task automatic t_mode3();
    logic [7:0] v; int r; logic od, pp;
    logic b, oe, rdy;
    int zeros = 0, rdys = 0;
    fillFlag = 1'b1;
    clkMode = 2'b11;
    syncBoundary();
    for (int i = 0; i < 32; i++) begin
      pulse(1'b0, 1'b0, b, oe, rdy);
      if (!b) zeros++;
      if (rdy) rdys++;
    end
    chk("R5 mode 3 forces ones fill", zeros, 0);
    chk("R10 one octet per 32 enables", rdys, 1);
    clkMode = 2'b00;
    syncBoundary();
    readOctet(v, r, od, pp);
    chk("R5 flag returns after mode 3", v, FLAG);
  endtask

  // mode 1 or 2: alternate closed/open enables
  task automatic t_gated(input logic [1:0] mode, input string tag);
    logic [7:0] v;
    logic b, oe, rdy;
    int rdys = 0;
    fillFlag = 1'b1;
    clkMode = mode;
    syncBoundary();
    v = '0;
    for (int i = 0; i < 16; i++) begin
      if (mode == 2'b01) pulse(i[0], 1'b0, b, oe, rdy);
      else pulse(1'b0, i[0], b, oe, rdy);
      if (i[0]) v = {v[6:0], b};
      if (rdy) rdys++;
    end
    chk({tag, " gated octet"}, v, FLAG);
    chk({tag, " one boundary"}, rdys, 1);
    clkMode = 2'b00;
    syncBoundary();
  endtask

  task automatic t_ppBus();
    logic b, oe, rdy;
    int badIdle = 0, badData = 0, badOe = 0;
    busMode = 1'b1; pushPull = 1'b1; clkMode = 2'b10; fillFlag = 1'b0;
    syncBoundary();
    frameData = 8'h00;
    frameValid = 1'b1;
    for (int i = 0; i < 8; i++) begin
      pulse(1'b0, 1'b1, b, oe, rdy);
      if (b !== 1'b1) badIdle++;
      if (oe !== 1'b1) badOe++;
    end
    chk("R12 frame accepted at boundary", frameValid, 0);
    for (int i = 0; i < 16; i++) begin
      pulse(1'b0, i[0], b, oe, rdy);
      if (!i[0] && b !== 1'b1) badIdle++;
      if (i[0] && b !== 1'b0) badData++;
      if (oe !== 1'b1) badOe++;
    end
    chk("R12 bus drives 1 in fill and closed slot", badIdle, 0);
    chk("R12 bus drives data in open slot", badData, 0);
    chk("R12 push-pull oe held", badOe, 0);
    busMode = 1'b0; clkMode = 2'b00;
    syncBoundary();
  endtask

  task automatic t_ppLine();
    logic [7:0] v; int r; logic od, pp;
    fillFlag = 1'b1;
    syncBoundary();
    readOctet(v, r, od, pp);
    chk("R12 push-pull flag data", v, FLAG);
    chk("R12 push-pull oe always 1", pp, 1);
    pushPull = 1'b0;
    syncBoundary();
    readOctet(v, r, od, pp);
    chk("R13 back to open drain", od, 1);
  endtask

  task automatic t_dbl();
    logic b, oe, rdy;
    int bad = 0, rdyIdx = -1;
    fillFlag = 1'b1;
    dblRate = 1'b1;
    syncBoundary();
    for (int i = 0; i < 16; i++) begin
      pulse(1'b1, 1'b1, b, oe, rdy);
      if (b !== FLAG[7 - i/2]) bad++;
      if (rdy) rdyIdx = i;
    end
    chk("R11 double rate bit pairs", bad, 0);
    chk("R11 boundary after 16 enables", rdyIdx, 15);
    dblRate = 1'b0;
    syncBoundary();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_flag();
    t_midcfg();
    t_frame();
    t_bus();
    t_mode3();
    t_gated(2'b01, "R8");
    t_gated(2'b10, "R9");
    t_ppBus();
    t_ppLine();
    t_dbl();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule